// File: doc/BRIEF.md
# GPIO Bank with Masked Half-Word Output Writes

This block is one bank of general-purpose pins, up to 32 wide, behind a single-cycle register strobe interface. Per-pin output values, a direction register and a drive-enable register live in the bank. The current input levels come back through a read-only register after a two-flop synchronizer. A pin drives its pad only when its direction bit and its drive-enable bit are both 1.

Output values are never changed by read-modify-write. Two write-only ports each cover sixteen pins. The upper half of the written word is a per-bit keep mask and the lower half is the new value, so any single output can be flipped in one write without disturbing its neighbours. The bank width is a parameter, so a 22-pin bank is built from the same code. A parameter mask names pins that can never be inputs. Their direction bits always read as 1.

Register word addresses: 0 = low-half masked write, 1 = high-half masked write, 2 = input levels, 3 = direction, 4 = drive enable.

Top module: `gpio_bank`

## Requirements
- R1: After a synchronous reset, pin_out, pin_oe and rdata are all zero, and the drive-enable register reads zero. The direction register reads zero except for the pins in FORCE_OUT.
- R2: A write to address 0 updates output pin i (0..15) to wdata[i] when wdata[16+i] is 0, and leaves it unchanged when wdata[16+i] is 1. Pins 16 and up are untouched. The result is on pin_out after the write's clock edge.
- R3: A write to address 1 applies the same rule to pins 16+i (i = 0..15), using mask bit wdata[16+i] and data bit wdata[i]. Pins 0..15 are untouched.
- R4: Addresses 0 and 1 are write-only and read as zero. Writes to them do not change the direction or drive-enable registers.
- R5: A read of address 2 returns pin_in as sampled through two synchronizer flops. A write to address 2 changes nothing.
- R6: The direction register at address 3 is readable and writable, with bit value 1 meaning output.
- R7: The drive-enable register at address 4 is readable and writable.
- R8: pin_oe[i] is 1 exactly when direction bit i and drive-enable bit i are both 1. It follows a register write by one extra clock.
- R9: In a bank narrower than 32 pins, rdata bits at and above PIN_W read zero. Write data in those bits has no effect.
- R10: Direction bits of pins in FORCE_OUT (default pins 7 and 8) always read 1, whatever is written.
- R11: Read data appears on rdata in the cycle after rd_en. Reads of unmapped addresses 5..7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| pin_in | input | PIN_W | Pad input levels (asynchronous) |
| pin_out | output | PIN_W | Pad output values |
| pin_oe | output | PIN_W | Pad drive enable, 1 = drive |

## Verification
The bench aims at the masked writes. A fully masked write must change nothing. A write whose mask clears only one bit must change exactly that pin. An inverted mask sense would corrupt every unmasked neighbour, and a swapped half decode would move the wrong sixteen pins. A 22-pin instance receives the same traffic as a 32-pin one, so that upper-bit writes that wrongly stick or bleed into rdata show up. The bench checks the forced-output pins against writes of zero, and drive enable against each combination of direction and enable bits. A design that gated drive on only one of the two registers would drive input pins. Reads of the write-only and unmapped addresses must return zero rather than stale data.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BUS_W  = 32;
  localparam int HALF_W = 16;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    A_WR_LO = 3'd0,
    A_WR_HI = 3'd1,
    A_LEVEL = 3'd2,
    A_DIR   = 3'd3,
    A_DRV   = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg #(
  parameter int           W      = 32,
  parameter logic [W-1:0] FORCE1 = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] store_q;

  always_ff @(posedge clk) begin
    if (rst)     store_q <= '0;
    else if (we) store_q <= wdata;
  end

  // pinned bits read as one regardless of the stored value
  assign q = store_q | FORCE1;
endmodule

// File: rtl/gpio_out_data.sv
module gpio_out_data import gpio_bank_pkg::*; #(
  parameter int PIN_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [BUS_W-1:0] wdata,
  output logic [PIN_W-1:0] q
);
  for (genvar b = 0; b < PIN_W; b++) begin : g_bit
    localparam int HALF = b / HALF_W;
    localparam int POS  = b % HALF_W;
    logic sel;
    logic hit;

    if (HALF == 0) begin : g_lo
      assign sel = wr_lo;
    end else begin : g_hi
      assign sel = wr_hi;
    end

    // mask bit 0 lets the data bit through
    assign hit = sel && !wdata[HALF_W+POS];

    always_ff @(posedge clk) begin
      if (rst)      q[b] <= 1'b0;
      else if (hit) q[b] <= wdata[POS];
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank import gpio_bank_pkg::*; #(
  parameter int          PIN_W     = 32,
  parameter logic [31:0] FORCE_OUT = 32'h0000_0180
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe
);
  localparam logic [PIN_W-1:0] FORCE_EFF = FORCE_OUT[PIN_W-1:0];

  reg_addr_e        a;
  logic             wr_lo, wr_hi, wr_dir, wr_drv;
  logic [PIN_W-1:0] dir_q, drv_q, level, out_q;
  logic [BUS_W-1:0] rd_val;

  assign a      = reg_addr_e'(addr);
  assign wr_lo  = wr_en && (a == A_WR_LO);
  assign wr_hi  = wr_en && (a == A_WR_HI);
  assign wr_dir = wr_en && (a == A_DIR);
  assign wr_drv = wr_en && (a == A_DRV);

  gpio_out_data #(.PIN_W(PIN_W)) u_out (
    .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wdata(wdata), .q(out_q)
  );

  gpio_cfg_reg #(.W(PIN_W), .FORCE1(FORCE_EFF)) u_dir (
    .clk(clk), .rst(rst), .we(wr_dir), .wdata(wdata[PIN_W-1:0]), .q(dir_q)
  );

  gpio_cfg_reg #(.W(PIN_W), .FORCE1('0)) u_drv (
    .clk(clk), .rst(rst), .we(wr_drv), .wdata(wdata[PIN_W-1:0]), .q(drv_q)
  );

  gpio_sync #(.W(PIN_W)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(level)
  );

  always_comb begin
    rd_val = '0;
    case (a)
      A_LEVEL: rd_val[PIN_W-1:0] = level;
      A_DIR:   rd_val[PIN_W-1:0] = dir_q;
      A_DRV:   rd_val[PIN_W-1:0] = drv_q;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      pin_oe <= '0;
    end else begin
      rdata  <= rd_en ? rd_val : '0;
      pin_oe <= dir_q & drv_q;
    end
  end

  assign pin_out = out_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int          PIN_W     = 32,
  parameter logic [31:0] FORCE_OUT = 32'h0000_0180
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic [2:0]       addr,
  input logic [31:0]      wdata,
  input logic [31:0]      rdata,
  input logic [PIN_W-1:0] pin_out,
  input logic [PIN_W-1:0] pin_oe,
  input logic [PIN_W-1:0] dir_q,
  input logic [PIN_W-1:0] drv_q
);
  localparam logic [31:0] IMPL = (PIN_W >= 32) ? 32'hFFFF_FFFF : ((32'h1 << PIN_W) - 32'h1);
  localparam logic [PIN_W-1:0] FEFF = FORCE_OUT[PIN_W-1:0];

  logic [31:0] po32;
  always_comb begin
    po32 = '0;
    po32[PIN_W-1:0] = pin_out;
  end

  // R2
  lo_masked_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd0) |=> po32[15:0] ==
      ((($past(po32[15:0]) & $past(wdata[31:16])) |
        ($past(wdata[15:0]) & ~$past(wdata[31:16]))) & IMPL[15:0]));

  // R3
  hi_masked_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd1) |=> po32[31:16] ==
      ((($past(po32[31:16]) & $past(wdata[31:16])) |
        ($past(wdata[15:0]) & ~$past(wdata[31:16]))) & IMPL[31:16]));

  // R4
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr <= 3'd1) |=> rdata == 32'h0);

  // R11
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr >= 3'd5) |=> rdata == 32'h0);

  // R5
  level_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd2) |=> ($stable(pin_out) && $stable(dir_q) && $stable(drv_q)));

  // R8
  oe_follows_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pin_oe == ($past(dir_q) & $past(drv_q)));

  // R9
  upper_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rdata & ~IMPL) == 32'h0);

  // R10
  forced_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (dir_q & FEFF) == FEFF);
endmodule

bind gpio_bank gpio_bank_chk #(.PIN_W(PIN_W), .FORCE_OUT(FORCE_OUT)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .dir_q(dir_q), .drv_q(drv_q)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
  localparam logic [31:0] FW  = 32'h0000_0180;
  localparam logic [31:0] NM  = 32'h003F_FFFF;
  localparam int          NPW = 22;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] pin_in = '0;
  logic [31:0] rdata, rdata_n;
  logic [31:0] pin_out, pin_oe;
  logic [NPW-1:0] pin_out_n, pin_oe_n;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] m_out = '0, m_dir = '0, m_drv = '0;
  logic [31:0] n_out = '0, n_dir = '0, n_drv = '0;

  always #10 clk = ~clk;

  gpio_bank dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  gpio_bank #(.PIN_W(NPW), .FORCE_OUT(32'h0)) dut_n (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata_n), .pin_in(pin_in[NPW-1:0]),
    .pin_out(pin_out_n), .pin_oe(pin_oe_n)
  );

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] w, int half);
    logic [31:0] r = old;
    for (int i = 0; i < 16; i++)
      if (!w[16+i]) r[half*16+i] = w[i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      3'd0: begin m_out = merge(m_out, d, 0); n_out = merge(n_out, d, 0) & NM; end
      3'd1: begin m_out = merge(m_out, d, 1); n_out = merge(n_out, d, 1) & NM; end
      3'd3: begin m_dir = d; n_dir = d & NM; end
      3'd4: begin m_drv = d; n_drv = d & NM; end
      default: ;
    endcase
  endtask

  task automatic do_read(input logic [2:0] a, output logic [31:0] rw, output logic [31:0] rn);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    rw = rdata; rn = rdata_n;
  endtask

  task automatic check_pins(input string req);
    chk({req, " pin_out"}, pin_out, m_out);
    chk({req, " pin_out narrow"}, 32'(pin_out_n), n_out);
    @(negedge clk);
    chk("R8 pin_oe", pin_oe, (m_dir | FW) & m_drv);
    chk("R8 pin_oe narrow", 32'(pin_oe_n), n_dir & n_drv);
  endtask

  task automatic check_cfg();
    logic [31:0] rw, rn;
    do_read(3'd3, rw, rn);
    chk("R6 R10 dir read", rw, m_dir | FW);
    chk("R9 dir read narrow", rn, n_dir);
    do_read(3'd4, rw, rn);
    chk("R7 drv read", rw, m_drv);
    chk("R9 drv read narrow", rn, n_drv);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rw, rn, r;
    int seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 pin_out", pin_out, 32'h0);
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 rdata", rdata, 32'h0);
    check_cfg();

    // R10 forced pins stay output
    do_write(3'd3, 32'h0);
    check_pins("R10");
    check_cfg();

    // R2 fully masked write changes nothing
    do_write(3'd0, 32'hFFFF_1234);
    check_pins("R2 all masked");
    do_write(3'd0, 32'h0000_FFFF);
    check_pins("R2 all open");
    // R2 single bit clear
    do_write(3'd0, 32'hFFDF_0000);
    check_pins("R2 single bit");
    // R3 upper half, touching unimplemented pins on narrow bank (R9)
    do_write(3'd1, 32'h0000_FFFF);
    check_pins("R3 R9 upper open");
    do_write(3'd1, 32'hFFFE_0000);
    check_pins("R3 single bit");

    // R8 direction/drive combinations
    do_write(3'd3, 32'h0000_00F0);
    do_write(3'd4, 32'h0000_03CC);
    check_pins("R8 combo");
    check_cfg();

    // R4 write-only reads and no side effects
    do_read(3'd0, rw, rn);
    chk("R4 read lo port", rw, 32'h0);
    do_read(3'd1, rw, rn);
    chk("R4 read hi port", rw, 32'h0);
    chk("R4 read hi port narrow", rn, 32'h0);
    check_cfg();

    // R11 unmapped reads
    for (int a = 5; a < 8; a++) begin
      do_read(3'(a), rw, rn);
      chk("R11 unmapped read", rw, 32'h0);
    end

    // R5 level write ignored, level read
    do_write(3'd2, 32'hFFFF_FFFF);
    check_pins("R5 level write");
    check_cfg();

    // Random mix
    for (int it = 0; it < 300; it++) begin
      r = $urandom;
      case ($urandom % 5)
        0: begin do_write(3'd0, r); check_pins("R2 random"); end
        1: begin do_write(3'd1, r); check_pins("R3 random"); end
        2: begin do_write(3'd3, r); check_pins("R6 random"); check_cfg(); end
        3: begin do_write(3'd4, r); check_pins("R7 random"); check_cfg(); end
        default: begin
          @(negedge clk);
          pin_in = r;
          repeat (3) @(negedge clk);
          do_read(3'd2, rw, rn);
          chk("R5 level read", rw, r);
          chk("R5 R9 level read narrow", rn, r & NM);
        end
      endcase
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule